// File: doc/BRIEF.md
# Serial Shift Interface Engine

This block is a small serial engine built around one shift register that the host reads and writes directly. One rising event of the selected serial clock samples the data-in pin into the low end of the register and moves every bit one place toward the top. The top bit reaches the outside world through a level-sensitive hold stage, so outgoing data changes on the opposite clock phase from the one that samples incoming data. No receive buffer exists: the host must fetch a received byte before the next transfer starts shifting over it.

The engine runs in three-wire mode, with separate data-out, data-in and clock lines, or in two-wire mode, where data and clock are open-drain and the block only ever pulls a line low. Either mode can act as master or slave. The shift clock comes from one of three sources: the clock pin, a host strobe, or a timer match pulse. A counter advances on every clock edge, so sixteen edges make one byte, and wrapping sets an overflow flag. In two-wire mode a start detector watches the bus. The clock line is held low while a start or overflow flag waits for the host. Byte protocol, addressing and acknowledge are left to software.

The start detector is a state machine with four states. ST_OFF is used while two-wire mode is off. ST_WAIT waits for both lines high. ST_ARMED has seen both lines high. ST_HELD means a start was found and the flag is set. The transitions are as follows. Any state goes to ST_OFF when two-wire mode is off. ST_OFF goes to ST_WAIT when two-wire mode is on. ST_WAIT goes to ST_ARMED when clock and data are both high. ST_ARMED goes to ST_HELD when data is low while clock is high and no start clear is written. ST_ARMED goes to ST_WAIT when the clock goes low, or when data falls in the same cycle as a start clear. ST_HELD goes to ST_WAIT on a start clear.

Top module: `ssi_engine`

## Requirements
- R1: Asynchronous active-low reset leaves the shift register, counter and both flags at zero, the internal clock phase and the output hold stage at 1, both pull outputs low and both interrupts low.
- R2: A host data write loads the shift register on the next edge, and it wins over a shift in the same cycle.
- R3: On each rising event of the selected clock the register shifts toward its top bit and takes the data-in pin as its new bit 0, in both wire modes.
- R4: The counter (status bits 3:0) advances by one on every rising and every falling clock event. An advance from 15 sets the overflow flag (status bit 4).
- R5: A host status write loads the counter from bits 3:0. A 1 in bit 4 clears the overflow flag and a 1 in bit 5 clears the start flag. This write takes priority over a clock event or a start detection in the same cycle.
- R6: The output hold stage copies the register's top bit one cycle later while the selected clock level is low, and it keeps its value while that level is high.
- R7: In three-wire mode the data-out pin shows the hold stage and both pull outputs stay low. In two-wire mode the data-out pin is 1 and the data pull is active exactly when the hold stage is 0.
- R8: The clock source code is 0 for the clock pin, 1 for the host strobe, 2 for the timer match and 3 for none. With source 1 or 2 each pulse toggles an internal phase (reset 1) that drives the clock output; a pulse from high is a falling event and a pulse from low is a rising event. Pulses from sources that are not selected have no effect.
- R9: In two-wire mode the start flag (status bit 5) is set one cycle after the data-in pin is low with the clock pin high, following a cycle with both high. The start flag is never set in three-wire mode.
- R10: In two-wire mode the clock pull is active while the start flag or the overflow flag is set, or while source 1 or 2 is selected and the internal phase is low.
- R11: Each interrupt output is its flag gated by its own enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wire2 | input | 1 | 1 selects two-wire mode, 0 selects three-wire mode |
| clk_src | input | 2 | Shift clock source code (R8) |
| ie_start | input | 1 | Start interrupt enable |
| ie_ovf | input | 1 | Overflow interrupt enable |
| host_wr_data | input | 1 | Host write strobe for the shift register |
| host_wdata | input | 8 | Host write data for the shift register |
| host_wr_stat | input | 1 | Host write strobe for the status word |
| host_wstat | input | 6 | Status write: bit 5 clears start, bit 4 clears overflow, bits 3:0 counter |
| host_rdata | output | 8 | Shift register contents |
| host_rstat | output | 6 | Status: start flag, overflow flag, counter |
| sw_strobe | input | 1 | Host clock strobe pulse |
| tmr_match | input | 1 | Timer compare match pulse |
| sclk_in | input | 1 | Clock pin level (three-wire clock or two-wire SCL) |
| di_in | input | 1 | Data-in pin level (three-wire input or two-wire SDA) |
| do_out | output | 1 | Three-wire data-out pin |
| sclk_out | output | 1 | Internal clock phase for master operation |
| sda_pull | output | 1 | Pull the two-wire data line low |
| scl_pull | output | 1 | Pull the two-wire clock line low |
| irq_start | output | 1 | Start condition interrupt |
| irq_ovf | output | 1 | Counter overflow interrupt |

## Verification
Three pairs of events can land in the same cycle. A host status write can meet a clock edge. A host data write can meet a rising event. A start clear can meet the falling data line that would set the start flag. The bench forces each pair by changing the clock or data pin on the same falling edge of the system clock that raises the write strobe. It then checks that the counter holds the written value, the register holds the written byte, and the start flag stays clear. A behavioural model applies the same priorities, and a long random phase where writes overlap serial activity is compared with that model on every cycle.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

    typedef enum logic [1:0] {
        SRC_PIN   = 2'd0,
        SRC_SOFT  = 2'd1,
        SRC_TIMER = 2'd2,
        SRC_NONE  = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ARMED = 2'd2,
        ST_HELD  = 2'd3
    } start_state_e;

endpackage

// File: rtl/ssi_clk_sel.sv
module ssi_clk_sel
    import ssi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       sw_strobe,
    input  logic       tmr_match,
    input  logic       sclk_in,
    output logic       level,
    output logic       rise,
    output logic       fall,
    output logic       phase,
    output logic       internal
);

    clk_src_e sel;
    logic     pulse;
    logic     sclk_q;
    logic     phase_q;

    assign sel = clk_src_e'(src);

    always_comb begin
        pulse    = 1'b0;
        internal = 1'b0;
        case (sel)
            SRC_SOFT:  begin pulse = sw_strobe; internal = 1'b1; end
            SRC_TIMER: begin pulse = tmr_match; internal = 1'b1; end
            default:   begin pulse = 1'b0;      internal = 1'b0; end
        endcase
    end

    always_comb begin
        if (sel == SRC_PIN) begin
            level = sclk_in;
            rise  = sclk_in & ~sclk_q;
            fall  = ~sclk_in & sclk_q;
        end else begin
            level = phase_q;
            rise  = pulse & ~phase_q;
            fall  = pulse & phase_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b1;
            phase_q <= 1'b1;
        end else begin
            sclk_q <= sclk_in;
            if (pulse) phase_q <= ~phase_q;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_cnt,
    input  logic [CNT_W-1:0]  wcnt,
    input  logic              clr_ovf,
    input  logic              rise,
    input  logic              fall,
    input  logic              level,
    input  logic              di,
    output logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf,
    output logic              lat
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic any_edge;
    assign any_edge = rise | fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (wr_data) begin
            data <= wdata;
        end else if (rise) begin
            data <= {data[DATA_W-2:0], di};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_cnt) begin
            cnt <= wcnt;
        end else if (any_edge) begin
            cnt <= cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (clr_ovf) begin
            ovf <= 1'b0;
        end else if (!wr_cnt && any_edge && cnt == CNT_TOP) begin
            ovf <= 1'b1;
        end
    end

    // level-sensitive hold stage, sampled on the system clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat <= 1'b1;
        end else if (!level) begin
            lat <= data[DATA_W-1];
        end
    end

endmodule

// File: rtl/ssi_start_fsm.sv
module ssi_start_fsm
    import ssi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl,
    input  logic sda,
    input  logic clr,
    output logic flag
);

    start_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   state_nx = ST_WAIT;
                ST_WAIT:  if (scl && sda) state_nx = ST_ARMED;
                ST_ARMED: begin
                    if (scl && !sda)  state_nx = clr ? ST_WAIT : ST_HELD;
                    else if (!scl)    state_nx = ST_WAIT;
                end
                ST_HELD:  if (clr) state_nx = ST_WAIT;
            endcase
        end
    end

    always_comb begin
        flag = (state == ST_HELD);
    end

endmodule

// File: rtl/ssi_engine.sv
module ssi_engine #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wire2,
    input  logic [1:0]        clk_src,
    input  logic              ie_start,
    input  logic              ie_ovf,
    input  logic              host_wr_data,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr_stat,
    input  logic [CNT_W+1:0]  host_wstat,
    output logic [DATA_W-1:0] host_rdata,
    output logic [CNT_W+1:0]  host_rstat,
    input  logic              sw_strobe,
    input  logic              tmr_match,
    input  logic              sclk_in,
    input  logic              di_in,
    output logic              do_out,
    output logic              sclk_out,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic              irq_start,
    output logic              irq_ovf
);

    localparam int OVF_BIT   = CNT_W;
    localparam int START_BIT = CNT_W + 1;

    logic             clk_level, rise, fall, phase, internal;
    logic             edge_any;
    logic [CNT_W-1:0] cnt;
    logic             ovf, dout_lat, start_flag;
    logic             clr_ovf, clr_start;

    assign clr_ovf   = host_wr_stat & host_wstat[OVF_BIT];
    assign clr_start = host_wr_stat & host_wstat[START_BIT];
    assign edge_any  = rise | fall;

    ssi_clk_sel u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (clk_src),
        .sw_strobe (sw_strobe),
        .tmr_match (tmr_match),
        .sclk_in   (sclk_in),
        .level     (clk_level),
        .rise      (rise),
        .fall      (fall),
        .phase     (phase),
        .internal  (internal)
    );

    ssi_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (host_wr_data),
        .wdata   (host_wdata),
        .wr_cnt  (host_wr_stat),
        .wcnt    (host_wstat[CNT_W-1:0]),
        .clr_ovf (clr_ovf),
        .rise    (rise),
        .fall    (fall),
        .level   (clk_level),
        .di      (di_in),
        .data    (host_rdata),
        .cnt     (cnt),
        .ovf     (ovf),
        .lat     (dout_lat)
    );

    ssi_start_fsm u_start (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (wire2),
        .scl    (sclk_in),
        .sda    (di_in),
        .clr    (clr_start),
        .flag   (start_flag)
    );

    assign host_rstat = {start_flag, ovf, cnt};
    assign do_out     = wire2 ? 1'b1 : dout_lat;
    assign sda_pull   = wire2 & ~dout_lat;
    assign scl_pull   = wire2 & (start_flag | ovf | (internal & ~phase));
    assign sclk_out   = phase;
    assign irq_start  = start_flag & ie_start;
    assign irq_ovf    = ovf & ie_ovf;

endmodule

// File: rtl/ssi_engine_chk.sv
module ssi_engine_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wire2,
    input logic [1:0]        clk_src,
    input logic              sw_strobe,
    input logic              host_wr_data,
    input logic [DATA_W-1:0] host_wdata,
    input logic              host_wr_stat,
    input logic [CNT_W-1:0]  host_wcnt,
    input logic [DATA_W-1:0] host_rdata,
    input logic [CNT_W+1:0]  host_rstat,
    input logic              sclk_out,
    input logic              sda_pull,
    input logic              scl_pull,
    input logic              edge_any,
    input logic              clk_level,
    input logic              dout_lat
);

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_data |=> host_rdata == $past(host_wdata));

    // R5
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_stat |=> host_rstat[CNT_W-1:0] == $past(host_wcnt));

    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rstat[CNT_W-1:0] == {CNT_W{1'b1}} && edge_any && !host_wr_stat)
        |=> host_rstat[CNT_W]);

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_level |=> dout_lat == $past(dout_lat));

    // R8
    soft_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src == 2'd1 && sw_strobe) |=> sclk_out != $past(sclk_out));

    // R7
    three_wire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wire2 |-> (!sda_pull && !scl_pull));

    // R9
    start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wire2 |=> !host_rstat[CNT_W+1]);

endmodule

bind ssi_engine ssi_engine_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wire2        (wire2),
    .clk_src      (clk_src),
    .sw_strobe    (sw_strobe),
    .host_wr_data (host_wr_data),
    .host_wdata   (host_wdata),
    .host_wr_stat (host_wr_stat),
    .host_wcnt    (host_wstat[CNT_W-1:0]),
    .host_rdata   (host_rdata),
    .host_rstat   (host_rstat),
    .sclk_out     (sclk_out),
    .sda_pull     (sda_pull),
    .scl_pull     (scl_pull),
    .edge_any     (edge_any),
    .clk_level    (clk_level),
    .dout_lat     (dout_lat)
);

// File: tb/tb_ssi_engine.sv
module tb_ssi_engine;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wire2 = 1'b0;
    logic [1:0] clk_src = 2'd0;
    logic       ie_start = 1'b0, ie_ovf = 1'b0;
    logic       host_wr_data = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_wr_stat = 1'b0;
    logic [5:0] host_wstat = 6'h00;
    logic [7:0] host_rdata;
    logic [5:0] host_rstat;
    logic       sw_strobe = 1'b0, tmr_match = 1'b0;
    logic       sclk_in = 1'b1, di_in = 1'b1;
    logic       do_out, sclk_out, sda_pull, scl_pull, irq_start, irq_ovf;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    bit run  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssi_engine dut (
        .clk(clk), .rst_n(rst_n), .wire2(wire2), .clk_src(clk_src),
        .ie_start(ie_start), .ie_ovf(ie_ovf),
        .host_wr_data(host_wr_data), .host_wdata(host_wdata),
        .host_wr_stat(host_wr_stat), .host_wstat(host_wstat),
        .host_rdata(host_rdata), .host_rstat(host_rstat),
        .sw_strobe(sw_strobe), .tmr_match(tmr_match),
        .sclk_in(sclk_in), .di_in(di_in), .do_out(do_out),
        .sclk_out(sclk_out), .sda_pull(sda_pull), .scl_pull(scl_pull),
        .irq_start(irq_start), .irq_ovf(irq_ovf)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got %0h exp %0h at %0t", req, got, exp, $time);
        end
    endtask

    // behavioural reference model
    int       m_data = 0, m_cnt = 0, m_st = 0;
    bit       m_ovf = 0, m_lat = 1, m_phase = 1, m_sq = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = 0; m_cnt = 0; m_st = 0;
            m_ovf = 0; m_lat = 1; m_phase = 1; m_sq = 1;
        end else begin
            bit lvl, rs, fl, pl, clr;
            int n_data, n_cnt, n_st;
            bit n_ovf, n_lat;
            pl  = (clk_src == 2'd1 && sw_strobe) || (clk_src == 2'd2 && tmr_match);
            if (clk_src == 2'd0) begin
                lvl = sclk_in; rs = sclk_in && !m_sq; fl = !sclk_in && m_sq;
            end else begin
                lvl = m_phase; rs = pl && !m_phase; fl = pl && m_phase;
            end
            n_lat  = lvl ? m_lat : m_data[7];
            n_data = host_wr_data ? int'(host_wdata)
                   : rs ? (((m_data * 2) % 256) + int'(di_in)) : m_data;
            n_cnt  = host_wr_stat ? int'(host_wstat[3:0])
                   : (rs || fl) ? (m_cnt + 1) % 16 : m_cnt;
            n_ovf  = m_ovf;
            if (host_wr_stat && host_wstat[4]) n_ovf = 0;
            else if (!host_wr_stat && (rs || fl) && m_cnt == 15) n_ovf = 1;
            clr  = host_wr_stat && host_wstat[5];
            n_st = m_st;
            if (!wire2) n_st = 0;
            else case (m_st)
                0: n_st = 1;
                1: if (sclk_in && di_in) n_st = 2;
                2: if (sclk_in && !di_in) n_st = clr ? 1 : 3;
                   else if (!sclk_in) n_st = 1;
                default: if (clr) n_st = 1;
            endcase
            if (pl) m_phase = !m_phase;
            m_sq = sclk_in; m_data = n_data; m_cnt = n_cnt; m_ovf = n_ovf;
            m_lat = n_lat; m_st = n_st;
        end
    end

    // cycle compare against the model
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && run) begin
            bit st, intl;
            st   = (m_st == 3);
            intl = (clk_src == 2'd1 || clk_src == 2'd2);
            chk("R3 shift register", host_rdata, m_data[7:0]);
            chk("R4 counter", host_rstat[3:0], m_cnt[3:0]);
            chk("R4 overflow flag", host_rstat[4], m_ovf);
            chk("R9 start flag", host_rstat[5], st);
            chk("R7 data out", do_out, wire2 ? 1'b1 : m_lat);
            chk("R7 data pull", sda_pull, wire2 & ~m_lat);
            chk("R10 clock pull", scl_pull, wire2 & (st | m_ovf | (intl & ~m_phase)));
            chk("R8 clock out", sclk_out, m_phase);
            chk("R11 start irq", irq_start, st & ie_start);
            chk("R11 ovf irq", irq_ovf, m_ovf & ie_ovf);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); host_wr_data = 1'b1; host_wdata = v;
        @(negedge clk); host_wr_data = 1'b0;
    endtask

    task automatic wr_stat(input logic [5:0] v);
        @(negedge clk); host_wr_stat = 1'b1; host_wstat = v;
        @(negedge clk); host_wr_stat = 1'b0;
    endtask

    task automatic pulse_soft(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sw_strobe = 1'b1;
            @(negedge clk); sw_strobe = 1'b0;
        end
    endtask

    task automatic pulse_tmr(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tmr_match = 1'b1;
            @(negedge clk); tmr_match = 1'b0;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R1 watchdog expired got 0 exp 1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] pat;
        cyc(3);
        // R1 reset state
        chk("R1 rdata", host_rdata, 8'h00);
        chk("R1 rstat", host_rstat, 6'h00);
        chk("R1 do_out", do_out, 1'b1);
        chk("R1 sclk_out", sclk_out, 1'b1);
        chk("R1 pulls", {sda_pull, scl_pull}, 2'b00);
        chk("R1 irqs", {irq_start, irq_ovf}, 2'b00);
        rst_n = 1'b1; run = 1'b1;
        cyc(2);

        // three-wire byte from the clock pin
        wr_data(8'hA5);
        pat = 8'h3C;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); sclk_in = 1'b0;
            cyc(2);
            if (i == 7) chk("R6 first out bit", do_out, 1'b1);
            if (i == 6) chk("R6 second out bit", do_out, 1'b0);
            @(negedge clk); sclk_in = 1'b1; di_in = pat[i];
            cyc(2);
        end
        chk("R3 received byte", host_rdata, 8'h3C);
        chk("R4 wrap sets overflow", host_rstat, 6'h10);

        // status write collides with a falling edge
        @(negedge clk); sclk_in = 1'b0; host_wr_stat = 1'b1; host_wstat = 6'h07;
        @(negedge clk); host_wr_stat = 1'b0;
        cyc(1);
        chk("R5 write beats edge", host_rstat, 6'h17);
        wr_stat(6'h17);
        cyc(1);
        chk("R5 overflow cleared", host_rstat, 6'h07);

        // data write collides with a rising edge
        @(negedge clk); sclk_in = 1'b1; di_in = 1'b0; host_wr_data = 1'b1; host_wdata = 8'h5A;
        @(negedge clk); host_wr_data = 1'b0;
        cyc(1);
        chk("R2 write beats shift", host_rdata, 8'h5A);
        chk("R4 edge still counted", host_rstat[3:0], 4'h8);

        // host strobe source
        clk_src = 2'd1;
        wr_data(8'h00);
        wr_stat(6'h30);
        di_in = 1'b1;
        pulse_soft(16);
        cyc(1);
        chk("R8 strobe byte", host_rdata, 8'hFF);
        chk("R8 strobe overflow", host_rstat, 6'h10);
        chk("R8 phase back high", sclk_out, 1'b1);

        // timer source, strobes ignored
        clk_src = 2'd2;
        wr_stat(6'h30);
        pulse_tmr(4);
        pulse_soft(2);
        cyc(1);
        chk("R8 timer count, strobe ignored", host_rstat, 6'h04);
        clk_src = 2'd3;
        pulse_tmr(2);
        pulse_soft(2);
        cyc(1);
        chk("R8 no source", host_rstat, 6'h04);

        // three-wire: falling data with clock high sets no start
        clk_src = 2'd0; sclk_in = 1'b1; di_in = 1'b1;
        cyc(3);
        @(negedge clk); di_in = 1'b0;
        cyc(2);
        chk("R9 no start in three-wire", host_rstat[5], 1'b0);

        // two-wire start detection and hold
        ie_start = 1'b1;
        @(negedge clk); wire2 = 1'b1; di_in = 1'b1;
        cyc(3);
        @(negedge clk); di_in = 1'b0;
        cyc(2);
        chk("R9 start flag", host_rstat[5], 1'b1);
        chk("R10 clock held", scl_pull, 1'b1);
        chk("R11 start irq", irq_start, 1'b1);
        wr_stat(6'h20);
        cyc(1);
        chk("R5 start cleared", host_rstat[5], 1'b0);
        chk("R10 clock released", scl_pull, 1'b0);

        // start clear collides with detection
        @(negedge clk); di_in = 1'b1;
        cyc(2);
        @(negedge clk); di_in = 1'b0; host_wr_stat = 1'b1; host_wstat = 6'h20;
        @(negedge clk); host_wr_stat = 1'b0;
        cyc(1);
        chk("R5 clear beats start", host_rstat[5], 1'b0);

        // two-wire data pull follows the hold stage
        wr_data(8'h00);
        @(negedge clk); sclk_in = 1'b0;
        cyc(2);
        chk("R7 data pulled low", sda_pull, 1'b1);
        chk("R7 data pin idle", do_out, 1'b1);

        // random overlap of writes and serial activity
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            if ($urandom_range(0, 199) == 0) wire2 = ~wire2;
            if ($urandom_range(0, 149) == 0) clk_src = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 63) == 0) {ie_start, ie_ovf} = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 2) == 0) sclk_in = ~sclk_in;
            if ($urandom_range(0, 3) == 0) di_in = ~di_in;
            sw_strobe    = ($urandom_range(0, 3) == 0);
            tmr_match    = ($urandom_range(0, 4) == 0);
            host_wr_data = ($urandom_range(0, 29) == 0);
            host_wdata   = 8'($urandom);
            host_wr_stat = ($urandom_range(0, 19) == 0);
            host_wstat   = 6'($urandom);
        end
        @(negedge clk);
        host_wr_data = 1'b0; host_wr_stat = 1'b0; sw_strobe = 1'b0; tmr_match = 1'b0;
        cyc(2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule